// File: doc/BRIEF.md
# Sticky Fault Status Register

This block collects asynchronous hardware fault reports from cache, memory and system-bus logic into one 64-bit status word that software can read and write. Each fault source raises a one-cycle strobe on its own lane of `evt_i`. The block sets the matching sticky flag. It flags a repeated fault of a kind that is already pending. It also captures a parity syndrome for the cache tag or the cache data bus when a fault of that kind arrives.

Software reads the word at any time without disturbing it. To clear flags, software writes ones to them. The syndrome fields are read-only. Each field follows the flags it is tied to: it holds the syndrome of the most important fault seen since those flags were last all clear, and it returns to zero once they are all clear.

A single interrupt output stays high while any fault of the disrupting class is pending.

Top module: `fsr_top`

## Requirements
- R1: After synchronous reset, `rd_data_o` is all zero and `irq_o` is low.
- R2: A strobe on `evt_i[k]` sets status bit 20+k on the next clock edge. The lanes k=0..11 are, in order: correctable ECC, uncorrectable ECC, cache data parity, write-back data parity, copy-out parity, fill/noncacheable data parity, bus error, bus time-out, interrupt-vector uncorrectable, cache tag parity, system address parity, privileged access.
- R3: A write with `wr_en_i` high clears every status bit in 32:20 whose `wr_data_i` bit is 1. Bits written 0 keep their value. With no write, the flags hold. Reading has no side effect.
- R4: If a write clears a flag in the same cycle that the flag's strobe fires, the flag is set after that edge. A repeat is not reported, because the clear takes effect first.
- R5: Bit 32 (multiple error) is set when a strobe arrives for a flag that is already set and is not being cleared in that cycle. Bit 32 is cleared by writing 1 to bit 32.
- R6: Writes to bits 63:33 and 19:0 have no effect. Bits 63:33 always read zero.
- R7: Bits 15:0 capture `data_synd_i` when a data-parity fault (lanes 2..5) arrives and no data-parity flag is pending. Syndrome bit i stands for byte lane i, which is bits 8i+7:8i of the 128-bit cache data bus.
- R8: Data-parity priority runs from highest to lowest as lane 2, lane 3, lane 4, lane 5. A fault of strictly higher priority than the one captured replaces the syndrome. A fault of equal or lower priority leaves it unchanged.
- R9: When all data-parity flags are clear after a write, bits 15:0 read zero. The next data-parity fault then captures a fresh syndrome, even if it arrives in the same cycle as the clear. While any data-parity flag stays set, the captured syndrome and its priority are kept.
- R10: Bits 19:16 capture `tag_synd_i` on the first cache tag parity fault (lane 9). A repeat of that fault while its flag is set does not replace the field. Clearing the flag zeroes the field.
- R11: `irq_o` is high exactly while at least one of status bits 20, 21 or 22 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 12 | Per-cycle fault strobes, one per sticky flag lane |
| tag_synd_i | input | 4 | Tag parity syndrome, used with lane 9 |
| data_synd_i | input | 16 | Per-byte data parity syndrome, used with lanes 2..5 |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 64 | Write data; ones clear sticky flags |
| rd_data_o | output | 64 | Current register contents |
| irq_o | output | 1 | Disrupting-fault pending |

## Verification
The checker assumes that every input is driven to a known value on each clock edge. It also assumes that a syndrome input matters only in a cycle where one of its lanes strobes. It places no limit on how strobes and writes overlap, so same-cycle clears and faults, repeats and multi-lane bursts are all legal.

The stimulus changes inputs only on the falling edge. It sends known zeros on the syndrome inputs whenever no lane that uses them is active. It deliberately combines clears with faults on the same lane, and it sends syndromes of equal, lower and higher priority than the one already held.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int REG_W     = 64;
    localparam int N_EVT     = 12;
    localparam int FLAG_LSB  = 20;
    localparam int MULTI_BIT = FLAG_LSB + N_EVT;
    localparam int RSVD_W    = REG_W - MULTI_BIT - 1;
    localparam int DSYN_W    = 16;
    localparam int TSYN_W    = 4;
    localparam int TSYN_LSB  = DSYN_W;

    // lane indices, in the order the status word lays them out
    typedef enum int unsigned {
        EV_CORR    = 0,
        EV_UNCORR  = 1,
        EV_CDATA   = 2,
        EV_WBACK   = 3,
        EV_COPYOUT = 4,
        EV_FILL    = 5,
        EV_BUSERR  = 6,
        EV_TIMEOUT = 7,
        EV_IVEC    = 8,
        EV_CTAG    = 9,
        EV_ADDRPAR = 10,
        EV_PRIV    = 11
    } evt_lane_e;

    // data parity group: contiguous lanes, lowest index = highest priority
    localparam int DGRP_LSB = int'(EV_CDATA);
    localparam int DGRP_N   = int'(EV_FILL) - int'(EV_CDATA) + 1;
    localparam int TGRP_LSB = int'(EV_CTAG);
    localparam int TGRP_N   = 1;

    typedef logic [N_EVT-1:0] evt_vec_t;

    localparam evt_vec_t IRQ_MASK =
        evt_vec_t'((1 << int'(EV_CORR)) | (1 << int'(EV_UNCORR)) | (1 << int'(EV_CDATA)));

    typedef struct packed {
        logic     multi;
        evt_vec_t flags;
    } sticky_t;

    function automatic logic [REG_W-1:0] pack_status(
        input sticky_t            st,
        input logic [TSYN_W-1:0]  tsyn,
        input logic [DSYN_W-1:0]  dsyn
    );
        return {{RSVD_W{1'b0}}, st.multi, st.flags, tsyn, dsyn};
    endfunction

endpackage

// File: rtl/fsr_wr_decode.sv
module fsr_wr_decode
    import fsr_pkg::*;
(
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output sticky_t          clr_o
);
    // only the sticky field responds to writes
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data_i[REG_W-1:MULTI_BIT+1], wr_data_i[FLAG_LSB-1:0]};

    always_comb begin
        clr_o = '0;
        if (wr_en_i) begin
            clr_o.multi = wr_data_i[MULTI_BIT];
            clr_o.flags = wr_data_i[MULTI_BIT-1:FLAG_LSB];
        end
    end
endmodule

// File: rtl/fsr_flag_bank.sv
module fsr_flag_bank
    import fsr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_vec_t evt_i,
    input  sticky_t  clr_i,
    output sticky_t  state_o,
    output evt_vec_t kept_o
);
    sticky_t  st_q;
    sticky_t  st_d;
    evt_vec_t kept;
    evt_vec_t repeat_hit;

    always_comb begin
        // clear is applied before the new strobes are merged
        kept        = st_q.flags & ~clr_i.flags;
        repeat_hit  = evt_i & kept;
        st_d.flags  = kept | evt_i;
        st_d.multi  = (st_q.multi & ~clr_i.multi) | (|repeat_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign state_o = st_q;
    assign kept_o  = kept;
endmodule

// File: rtl/fsr_synd_slot.sv
module fsr_synd_slot #(
    parameter int NSRC = 4,
    parameter int SW   = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] kept_i,
    input  logic [NSRC-1:0] evt_i,
    input  logic [SW-1:0]   synd_i,
    output logic [SW-1:0]   synd_o
);
    localparam int RW = $clog2(NSRC + 1);

    logic [RW-1:0] rank_q;
    logic [RW-1:0] rank_d;
    logic [RW-1:0] rank_eff;
    logic [RW-1:0] rank_new;
    logic [SW-1:0] synd_q;
    logic [SW-1:0] synd_d;
    logic [SW-1:0] synd_eff;

    always_comb begin
        // rank NSRC for index 0 (top priority) down to 1; 0 means empty
        rank_new = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (evt_i[i]) rank_new = RW'(NSRC - i);
        end
        if (|kept_i) begin
            rank_eff = rank_q;
            synd_eff = synd_q;
        end else begin
            rank_eff = '0;
            synd_eff = '0;
        end
        rank_d = rank_eff;
        synd_d = synd_eff;
        if (rank_new > rank_eff) begin
            rank_d = rank_new;
            synd_d = synd_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rank_q <= '0;
            synd_q <= '0;
        end else begin
            rank_q <= rank_d;
            synd_q <= synd_d;
        end
    end

    assign synd_o = synd_q;
endmodule

// File: rtl/fsr_top.sv
module fsr_top
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_EVT-1:0]  evt_i,
    input  logic [TSYN_W-1:0] tag_synd_i,
    input  logic [DSYN_W-1:0] data_synd_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              irq_o
);
    sticky_t     clr;
    sticky_t     state;
    evt_vec_t    kept;
    logic [DSYN_W-1:0] dsyn;
    logic [TSYN_W-1:0] tsyn;

    fsr_wr_decode u_dec (
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .clr_o     (clr)
    );

    fsr_flag_bank u_flags (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt_i),
        .clr_i   (clr),
        .state_o (state),
        .kept_o  (kept)
    );

    fsr_synd_slot #(.NSRC(DGRP_N), .SW(DSYN_W)) u_dslot (
        .clk    (clk),
        .rst    (rst),
        .kept_i (kept[DGRP_LSB +: DGRP_N]),
        .evt_i  (evt_i[DGRP_LSB +: DGRP_N]),
        .synd_i (data_synd_i),
        .synd_o (dsyn)
    );

    fsr_synd_slot #(.NSRC(TGRP_N), .SW(TSYN_W)) u_tslot (
        .clk    (clk),
        .rst    (rst),
        .kept_i (kept[TGRP_LSB +: TGRP_N]),
        .evt_i  (evt_i[TGRP_LSB +: TGRP_N]),
        .synd_i (tag_synd_i),
        .synd_o (tsyn)
    );

    assign rd_data_o = pack_status(state, tsyn, dsyn);
    assign irq_o     = |(state.flags & IRQ_MASK);
endmodule

// File: rtl/fsr_chk.sv
module fsr_chk
    import fsr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [N_EVT-1:0]  evt_i,
    input logic              wr_en_i,
    input logic [REG_W-1:0]  wr_data_i,
    input logic [REG_W-1:0]  rd_data_o,
    input logic              irq_o
);
    // R2
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rd_data_o[MULTI_BIT-1:FLAG_LSB] & $past(evt_i)) == $past(evt_i)));

    // R3
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> ((rd_data_o[MULTI_BIT-1:FLAG_LSB] & $past(rd_data_o[MULTI_BIT-1:FLAG_LSB]))
                      == $past(rd_data_o[MULTI_BIT-1:FLAG_LSB])));

    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> ((rd_data_o[MULTI_BIT-1:FLAG_LSB]
                      & $past(wr_data_i[MULTI_BIT-1:FLAG_LSB] & ~evt_i)) == '0));

    // R5
    repeat_sets_multi_chk: assert property (@(posedge clk) disable iff (rst)
        (|(evt_i & rd_data_o[MULTI_BIT-1:FLAG_LSB]
           & ~(wr_en_i ? wr_data_i[MULTI_BIT-1:FLAG_LSB] : '0))) |=> rd_data_o[MULTI_BIT]);

    // R6
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[REG_W-1:MULTI_BIT+1] == '0);

    // R9
    dsyn_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data_o[FLAG_LSB+DGRP_LSB +: DGRP_N] == '0) |-> (rd_data_o[DSYN_W-1:0] == '0));

    // R10
    tsyn_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_data_o[FLAG_LSB+TGRP_LSB] |-> (rd_data_o[TSYN_LSB +: TSYN_W] == '0));

    // R11
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (|rd_data_o[FLAG_LSB+2:FLAG_LSB]));

    // R11
    cause_raises_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (|rd_data_o[FLAG_LSB+2:FLAG_LSB]) |-> irq_o);
endmodule

bind fsr_top fsr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o)
);

// File: tb/fsr_top_bench.sv
module fsr_top_bench;
    import fsr_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_EVT-1:0]  evt_i = '0;
    logic [TSYN_W-1:0] tag_synd_i = '0;
    logic [DSYN_W-1:0] data_synd_i = '0;
    logic              wr_en_i = 1'b0;
    logic [REG_W-1:0]  wr_data_i = '0;
    logic [REG_W-1:0]  rd_data_o;
    logic              irq_o;

    always #5 clk = ~clk;

    fsr_top u_fsr_top (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt_i),
        .tag_synd_i  (tag_synd_i),
        .data_synd_i (data_synd_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .rd_data_o   (rd_data_o),
        .irq_o       (irq_o)
    );

    // status bit masks
    localparam logic [63:0] M_CE   = 64'd1 << 20;
    localparam logic [63:0] M_UE   = 64'd1 << 21;
    localparam logic [63:0] M_CD   = 64'd1 << 22;
    localparam logic [63:0] M_WB   = 64'd1 << 23;
    localparam logic [63:0] M_CO   = 64'd1 << 24;
    localparam logic [63:0] M_FL   = 64'd1 << 25;
    localparam logic [63:0] M_BE   = 64'd1 << 26;
    localparam logic [63:0] M_TO   = 64'd1 << 27;
    localparam logic [63:0] M_TG   = 64'd1 << 29;
    localparam logic [63:0] M_PR   = 64'd1 << 31;
    localparam logic [63:0] M_ME   = 64'd1 << 32;

    function automatic logic [11:0] ev(input logic [63:0] m);
        return m[31:20];
    endfunction

    typedef struct {
        logic [63:0] rd;
        logic        irq;
        string       req;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    task automatic drive(input logic [11:0] e, input logic [3:0] ts, input logic [15:0] ds,
                         input logic we, input logic [63:0] wd,
                         input logic [63:0] erd, input logic eirq, input string req);
        exp_t it;
        @(negedge clk);
        rst         = 1'b0;
        evt_i       = e;
        tag_synd_i  = ts;
        data_synd_i = ds;
        wr_en_i     = we;
        wr_data_i   = wd;
        it.rd  = erd;
        it.irq = eirq;
        it.req = req;
        q.push_back(it);
    endtask

    task automatic pulse_reset(input string req);
        exp_t it;
        @(negedge clk);
        rst = 1'b1;
        evt_i = '0; tag_synd_i = '0; data_synd_i = '0; wr_en_i = 1'b0; wr_data_i = '0;
        it.rd = '0; it.irq = 1'b0; it.req = req;
        q.push_back(it);
    endtask

    // monitor: compares one expected item after each edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() != 0) begin
                e = q.pop_front();
                total++;
                if (rd_data_o !== e.rd || irq_o !== e.irq) begin
                    bad++;
                    $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b",
                             e.req, rd_data_o, irq_o, e.rd, e.irq);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1 reset state
        drive(0, 0, 0, 0, 0, 64'd0, 0, "R1 reset state");
        // R2 single and multiple lanes
        drive(ev(M_BE), 0, 0, 0, 0, M_BE, 0, "R2 bus error");
        drive(ev(M_TO|M_PR), 0, 0, 0, 0, M_BE|M_TO|M_PR, 0, "R2 two lanes");
        // R3 idle hold and zero write
        drive(0, 0, 0, 0, 0, M_BE|M_TO|M_PR, 0, "R3 hold");
        drive(0, 0, 0, 1, 64'd0, M_BE|M_TO|M_PR, 0, "R3 write zeros");
        drive(0, 0, 0, 1, M_BE, M_TO|M_PR, 0, "R3 write one clears");
        // R6 non-sticky bits ignore writes
        drive(0, 0, 0, 1, 64'hFFFF_FFFE_000F_FFFF, M_TO|M_PR, 0, "R6 ignored bits");
        // R5 repeat
        drive(ev(M_TO), 0, 0, 0, 0, M_TO|M_PR|M_ME, 0, "R5 repeat sets multi");
        drive(0, 0, 0, 1, M_ME, M_TO|M_PR, 0, "R5 multi clear");
        // R4 clear and event together
        drive(ev(M_PR), 0, 0, 1, M_PR, M_TO|M_PR, 0, "R4 clear then log");
        drive(0, 0, 0, 1, M_TO|M_PR, 64'd0, 0, "R3 clear all");
        // R7 data syndrome capture
        drive(ev(M_CO), 0, 16'h0010, 0, 0, M_CO|64'h0010, 0, "R7 first capture");
        // R8 priorities
        drive(ev(M_FL), 0, 16'h0F00, 0, 0, M_CO|M_FL|64'h0010, 0, "R8 lower kept");
        drive(ev(M_CO), 0, 16'h00FF, 0, 0, M_CO|M_FL|M_ME|64'h0010, 0, "R8 equal kept");
        drive(ev(M_CD), 0, 16'hA000, 0, 0, M_CD|M_CO|M_FL|M_ME|64'hA000, 1, "R8 higher replaces");
        drive(ev(M_WB), 0, 16'h0001, 0, 0, M_CD|M_WB|M_CO|M_FL|M_ME|64'hA000, 1, "R8 below top kept");
        // R9 / R11 partial clear keeps syndrome
        drive(0, 0, 0, 1, M_CD, M_WB|M_CO|M_FL|M_ME|64'hA000, 0, "R9 partial clear R11 irq low");
        drive(0, 0, 0, 1, M_WB|M_CO|M_FL|M_ME, 64'd0, 0, "R9 all clear zeroes");
        drive(ev(M_FL), 0, 16'h1234, 0, 0, M_FL|64'h1234, 0, "R9 fresh capture");
        drive(ev(M_FL), 0, 16'h5555, 1, M_FL, M_FL|64'h5555, 0, "R9 clear with capture R4");
        drive(0, 0, 0, 1, M_FL, 64'd0, 0, "R9 cleared");
        // R10 tag syndrome
        drive(ev(M_TG), 4'h9, 0, 0, 0, M_TG|64'h0009_0000, 0, "R10 tag capture");
        drive(ev(M_TG), 4'h3, 0, 0, 0, M_TG|M_ME|64'h0009_0000, 0, "R10 tag repeat kept");
        drive(0, 0, 0, 1, M_TG|M_ME, 64'd0, 0, "R10 tag cleared");
        // R11 interrupt
        drive(ev(M_CE), 0, 0, 0, 0, M_CE, 1, "R11 correctable");
        drive(ev(M_UE), 0, 0, 0, 0, M_CE|M_UE, 1, "R11 uncorrectable");
        drive(0, 0, 0, 1, M_CE, M_UE, 1, "R11 one left");
        drive(0, 0, 0, 1, M_UE, 64'd0, 0, "R11 drops");
        // all lanes at once
        drive(12'hFFF, 4'hC, 16'hBEEF, 0, 0, 64'h0000_0000_FFFC_BEEF, 1, "R2 R7 R10 burst");
        pulse_reset("R1 mid-run reset");
        drive(0, 0, 0, 0, 0, 64'd0, 0, "R1 after reset");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule